// File: doc/BRIEF.md
# SPI Bus Master with Fixed and Per-Word Slave Selection

This block is a serial peripheral interface master. A host drives it through a small register interface. It shifts words of 8 to 16 bits out on `mosi` and captures `miso` at the same time. It generates the serial clock and four active-low select lines. The target slave is chosen in one of two ways. In fixed selection, a slave code held in the mode register applies to every word. In per-word selection, each transmit word carries its own slave code. The 4-bit slave code either drives the four lines directly, or it is passed to the pins unchanged so that an external decoder can address up to fifteen slaves.

Each of four configuration registers describes one group of slaves. It sets the word length, the clock polarity and phase, the serial-clock divider, the delay from select assertion to the first clock edge, and the idle gap between words. The selected slave decides which configuration is used. All of these values are captured when a word starts. The transmit register and the receive register each buffer one word. A second word can therefore be queued while the first is on the wire. The status register reports transmit-empty, receive-full, overrun and mode fault. A low level on the external slave-select input while the master is enabled is a mode fault, and it turns the master off.

Register addresses (`bus_addr`): 0 control, 1 mode, 2 transmit, 3 receive, 4 status, 8 to 11 configuration 0 to 3. Reads are combinational. A read side effect takes place at the clock edge that ends a cycle in which `bus_rd` is high.

Top module: `spi_psel_master`

## Requirements
- R1: After reset, `cs_n` is 1111 and `sclk` is 0. The master is disabled, and status reads 0x1: bit0 is transmit-empty, bit1 is receive-full, bit2 is overrun and bit3 is mode fault. A transmit write (data [15:0], code [19:16]) made while the master is disabled starts nothing until control bit0 is written as 1.
- R2: When the master is enabled and a word is waiting, the word starts, and transmit-empty goes back to 1. A word written while another is being shifted starts on its own after the current word's gap. No host action is needed.
- R3: A word of N bits, where N = 8 + min(len, 8) and len is configuration bits [3:0], is sent MSB first from data[N-1:0] using exactly 2N serial-clock edges. The clock idles at cpol (bit4). With cpha (bit5) = 0, data is sampled on leading edges. With cpha = 1, it is sampled on trailing edges. The received bits are placed right-aligned in receive [15:0].
- R4: The serial-clock half period is H = max(div, 1) system clocks, where div is configuration bits [17:8]. The first clock edge comes exactly max(setup, H) clocks after the select lines assert, where setup is configuration bits [25:18].
- R5: After a word, the select lines return to 1111 for exactly max(gap, H) + 1 clocks before a queued word asserts them again, where gap is configuration bits [31:26].
- R6: Reading the receive register clears receive-full. A word that completes while receive-full is still 1 sets overrun, and reading the status register clears overrun.
- R7: With mode bit0 = 0 (fixed selection), the slave code is mode bits [7:4], and the code in the transmit word has no effect.
- R8: With mode bit0 = 1 (per-word selection), the code in the transmit word selects the slave, and mode bits [7:4] have no effect.
- R9: With mode bit1 = 0 (direct), line n is driven low during a word when bit n is the lowest 0 bit of the code. Code 1111 drives no line. The configuration index is that same n.
- R10: With mode bit1 = 1 (decoded), `cs_n` carries the code unchanged during a word, and the configuration index is code[3:2].
- R11: Between words every select line is high. The receive register stores in bits [19:16] the code that was used for the received word.
- R12: While the master is enabled, a low `ss_in_n` sets mode fault and disables the master. Reading the status register clears mode fault. No transfer starts until control bit0 is written as 1 again.
- R13: Writing control bit1 as 1 disables the master. A disabled master holds every select line high from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Slave select lines, active low or decoded code |
| ss_in_n | input | 1 | External slave-select sense for mode fault |

## Verification
A wrong configuration index is visible at the pins within one word. The distance from select assertion to the first clock edge changes, and so do the clock level and the edge count. A wrong shift or sample phase corrupts the captured byte or the received byte. This shows up in the first receive read after the word ends. A bad buffer or flag state shows up at the next status read, for example a lost queued word, a gap of the wrong length or an overrun that never sets. A mode fault that is not handled shows up at once, because a transfer starts when none should.

// File: rtl/spi_psel_pkg.sv
package spi_psel_pkg;

    localparam int DATA_W = 16;
    localparam int CODE_W = 4;
    localparam int NCS    = 4;
    localparam int DIV_W  = 10;
    localparam int DLY_W  = 8;
    localparam int CNT_W  = DIV_W;
    localparam int BITS_W = $clog2(DATA_W + 1);
    localparam int EDGE_W = BITS_W;
    localparam int IDX_W  = $clog2(NCS);

    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_MODE = 4'd1;
    localparam logic [3:0] A_TXD  = 4'd2;
    localparam logic [3:0] A_RXD  = 4'd3;
    localparam logic [3:0] A_STAT = 4'd4;
    localparam logic [3:0] A_CFG  = 4'd8;

    localparam logic [CODE_W-1:0] NO_SLAVE = '1;

    // per-slave-group transfer settings, 32 bits as written by the host
    typedef struct packed {
        logic [5:0]       gap;
        logic [DLY_W-1:0] setup;
        logic [DIV_W-1:0] div;
        logic [1:0]       spare;
        logic             cpha;
        logic             cpol;
        logic [3:0]       len;
    } cs_cfg_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_ACTIVE,
        ENG_GAP
    } eng_st_e;

    function automatic logic [IDX_W-1:0] cfg_index(input logic [CODE_W-1:0] code,
                                                   input logic dec);
        if (dec)          return code[3:2];
        else if (!code[0]) return 2'd0;
        else if (!code[1]) return 2'd1;
        else if (!code[2]) return 2'd2;
        else               return 2'd3;
    endfunction

    function automatic logic [CODE_W-1:0] cs_lines(input logic [CODE_W-1:0] code,
                                                   input logic dec);
        if (dec || code == NO_SLAVE) return code;
        return ~(4'b0001 << cfg_index(code, 1'b0));
    endfunction

    function automatic logic [BITS_W-1:0] word_bits(input logic [3:0] len);
        return (len > 4'd8) ? BITS_W'(DATA_W) : BITS_W'(8) + BITS_W'(len);
    endfunction

    function automatic logic [CNT_W-1:0] at_least(input logic [CNT_W-1:0] a,
                                                  input logic [CNT_W-1:0] b);
        return (a < b) ? b : a;
    endfunction

endpackage

// File: rtl/spi_psel_regs.sv
module spi_psel_regs
    import spi_psel_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [3:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                ss_in_n,
    output logic                en,
    output logic                tx_full,
    output logic [DATA_W-1:0]   tx_data,
    output logic [CODE_W-1:0]   tx_code,
    output logic                mode_var,
    output logic                mode_dec,
    output logic [CODE_W-1:0]   mode_code,
    output cs_cfg_t             cfg [NCS],
    input  logic                tx_take,
    input  logic                rx_done,
    input  logic [DATA_W-1:0]   rx_word,
    input  logic [CODE_W-1:0]   rx_code,
    output logic                rx_full,
    output logic                ovr,
    output logic                modf
);

    logic [DATA_W-1:0] rx_data_q;
    logic [CODE_W-1:0] rx_code_q;
    logic              fault;
    logic              wr_ctrl, wr_mode, wr_txd, rd_rxd, rd_stat;

    assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
    assign wr_mode = bus_wr && bus_addr == A_MODE;
    assign wr_txd  = bus_wr && bus_addr == A_TXD;
    assign rd_rxd  = bus_rd && bus_addr == A_RXD;
    assign rd_stat = bus_rd && bus_addr == A_STAT;
    assign fault   = en && !ss_in_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            en        <= 1'b0;
            mode_var  <= 1'b0;
            mode_dec  <= 1'b0;
            mode_code <= '0;
            tx_full   <= 1'b0;
            tx_data   <= '0;
            tx_code   <= '0;
            rx_full   <= 1'b0;
            rx_data_q <= '0;
            rx_code_q <= '0;
            ovr       <= 1'b0;
            modf      <= 1'b0;
        end else begin
            if (fault)
                en <= 1'b0;
            else if (wr_ctrl && bus_wdata[1])
                en <= 1'b0;
            else if (wr_ctrl && bus_wdata[0])
                en <= 1'b1;

            if (wr_mode) begin
                mode_var  <= bus_wdata[0];
                mode_dec  <= bus_wdata[1];
                mode_code <= bus_wdata[7:4];
            end

            if (wr_txd) begin
                tx_full <= 1'b1;
                tx_data <= bus_wdata[DATA_W-1:0];
                tx_code <= bus_wdata[19:16];
            end else if (tx_take) begin
                tx_full <= 1'b0;
            end

            if (rx_done) begin
                rx_full   <= 1'b1;
                rx_data_q <= rx_word;
                rx_code_q <= rx_code;
            end else if (rd_rxd) begin
                rx_full <= 1'b0;
            end

            if (rx_done && rx_full)
                ovr <= 1'b1;
            else if (rd_stat)
                ovr <= 1'b0;

            if (fault)
                modf <= 1'b1;
            else if (rd_stat)
                modf <= 1'b0;
        end
    end

    for (genvar g = 0; g < NCS; g++) begin : g_cfg
        localparam logic [3:0] MY_ADDR = A_CFG + 4'(g);
        always_ff @(posedge clk) begin
            if (rst)
                cfg[g] <= '0;
            else if (bus_wr && bus_addr == MY_ADDR)
                cfg[g] <= cs_cfg_t'(bus_wdata);
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata = {31'b0, en};
            A_MODE: bus_rdata = {24'b0, mode_code, 2'b0, mode_dec, mode_var};
            A_TXD:  bus_rdata = {12'b0, tx_code, tx_data};
            A_RXD:  bus_rdata = {12'b0, rx_code_q, rx_data_q};
            A_STAT: bus_rdata = {28'b0, modf, ovr, rx_full, !tx_full};
            default: begin
                if (bus_addr[3:2] == 2'b10)
                    bus_rdata = cfg[bus_addr[1:0]];
            end
        endcase
    end

endmodule

// File: rtl/spi_psel_engine.sv
module spi_psel_engine
    import spi_psel_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                tx_full,
    input  logic [DATA_W-1:0]   tx_data,
    input  logic [CODE_W-1:0]   tx_code,
    input  logic                mode_var,
    input  logic                mode_dec,
    input  logic [CODE_W-1:0]   mode_code,
    input  cs_cfg_t             cfg [NCS],
    input  logic                miso,
    output logic                tx_take,
    output logic                rx_done,
    output logic [DATA_W-1:0]   rx_word,
    output logic [CODE_W-1:0]   rx_code,
    output logic                sclk,
    output logic                mosi,
    output logic [CODE_W-1:0]   cs_n
);

    eng_st_e           st;
    logic [CNT_W-1:0]  cnt, half_q, gap_q;
    logic [EDGE_W-1:0] edge_q;
    logic [BITS_W-1:0] nbits_q;
    logic              cpol_q, cpha_q, sclk_q;
    logic [CODE_W-1:0] code_q, cs_q;
    logic [DATA_W-1:0] tx_sh, rx_sh, rx_next;

    // selection for the next word
    logic [CODE_W-1:0] sel_code;
    cs_cfg_t           sel_cfg;
    logic [CNT_W-1:0]  sel_half;
    logic [BITS_W-1:0] sel_bits;

    assign sel_code = mode_var ? tx_code : mode_code;
    assign sel_cfg  = cfg[cfg_index(sel_code, mode_dec)];
    assign sel_half = at_least(sel_cfg.div, CNT_W'(1));
    assign sel_bits = word_bits(sel_cfg.len);

    logic fire, lead, sample_now, last;

    assign tx_take    = en && st == ENG_IDLE && tx_full;
    assign fire       = en && st == ENG_ACTIVE && cnt == CNT_W'(1);
    assign lead       = !edge_q[0];
    assign sample_now = fire && (lead ^ cpha_q);
    assign last       = fire && ({1'b0, edge_q} == {nbits_q, 1'b0} - (BITS_W+1)'(1));
    assign rx_next    = {rx_sh[DATA_W-2:0], miso};

    assign rx_done = last;
    assign rx_word = (sample_now ? rx_next : rx_sh) & (16'hFFFF >> (BITS_W'(DATA_W) - nbits_q));
    assign rx_code = code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ENG_IDLE;
            cnt     <= '0;
            half_q  <= '0;
            gap_q   <= '0;
            edge_q  <= '0;
            nbits_q <= BITS_W'(8);
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
            sclk_q  <= 1'b0;
            code_q  <= NO_SLAVE;
            cs_q    <= NO_SLAVE;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else if (!en) begin
            st   <= ENG_IDLE;
            cs_q <= NO_SLAVE;
        end else begin
            case (st)
                ENG_IDLE: begin
                    if (tx_full) begin
                        code_q  <= sel_code;
                        cs_q    <= cs_lines(sel_code, mode_dec);
                        cpol_q  <= sel_cfg.cpol;
                        cpha_q  <= sel_cfg.cpha;
                        sclk_q  <= sel_cfg.cpol;
                        nbits_q <= sel_bits;
                        half_q  <= sel_half;
                        gap_q   <= at_least(CNT_W'(sel_cfg.gap), sel_half);
                        cnt     <= at_least(CNT_W'(sel_cfg.setup), sel_half);
                        edge_q  <= '0;
                        tx_sh   <= tx_data << (BITS_W'(DATA_W) - sel_bits);
                        rx_sh   <= '0;
                        st      <= ENG_ACTIVE;
                    end
                end
                ENG_ACTIVE: begin
                    if (fire) begin
                        sclk_q <= ~sclk_q;
                        edge_q <= edge_q + EDGE_W'(1);
                        cnt    <= half_q;
                        if (sample_now)
                            rx_sh <= rx_next;
                        else if (!(cpha_q && edge_q == '0))
                            tx_sh <= tx_sh << 1;
                        if (last) begin
                            cs_q <= NO_SLAVE;
                            cnt  <= gap_q;
                            st   <= ENG_GAP;
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ENG_GAP: begin
                    if (cnt == CNT_W'(1))
                        st <= ENG_IDLE;
                    else
                        cnt <= cnt - CNT_W'(1);
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    assign sclk = sclk_q;
    assign mosi = tx_sh[DATA_W-1];
    assign cs_n = cs_q;

endmodule

// File: rtl/spi_psel_master.sv
module spi_psel_master
    import spi_psel_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [3:0]  cs_n,
    input  logic        ss_in_n
);

    logic              en, tx_full, mode_var, mode_dec;
    logic [DATA_W-1:0] tx_data, rx_word;
    logic [CODE_W-1:0] tx_code, mode_code, rx_code;
    cs_cfg_t           cfg [NCS];
    logic              tx_take, rx_done, rx_full, ovr, modf;

    spi_psel_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ss_in_n   (ss_in_n),
        .en        (en),
        .tx_full   (tx_full),
        .tx_data   (tx_data),
        .tx_code   (tx_code),
        .mode_var  (mode_var),
        .mode_dec  (mode_dec),
        .mode_code (mode_code),
        .cfg       (cfg),
        .tx_take   (tx_take),
        .rx_done   (rx_done),
        .rx_word   (rx_word),
        .rx_code   (rx_code),
        .rx_full   (rx_full),
        .ovr       (ovr),
        .modf      (modf)
    );

    spi_psel_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .tx_full   (tx_full),
        .tx_data   (tx_data),
        .tx_code   (tx_code),
        .mode_var  (mode_var),
        .mode_dec  (mode_dec),
        .mode_code (mode_code),
        .cfg       (cfg),
        .miso      (miso),
        .tx_take   (tx_take),
        .rx_done   (rx_done),
        .rx_word   (rx_word),
        .rx_code   (rx_code),
        .sclk      (sclk),
        .mosi      (mosi),
        .cs_n      (cs_n)
    );

endmodule

// File: rtl/spi_psel_chk.sv
module spi_psel_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       mode_dec,
    input logic       rx_done,
    input logic       rx_full,
    input logic       ovr,
    input logic       modf,
    input logic       ss_in_n,
    input logic [3:0] cs_n
);

    AST_CS_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cs_n == 4'hF)); // R13

    AST_DIRECT_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
        !mode_dec |-> ($countones(~cs_n) <= 1)); // R9

    AST_MODF_DISABLES: assert property (@(posedge clk) disable iff (rst)
        (en && !ss_in_n) |=> (modf && !en)); // R12

    AST_OVERRUN_ON_UNREAD: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rx_full) |=> ovr); // R6

    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> (cs_n == 4'hF && rx_full)); // R11

endmodule

bind spi_psel_master spi_psel_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .mode_dec (mode_dec),
    .rx_done  (rx_done),
    .rx_full  (rx_full),
    .ovr      (ovr),
    .modf     (modf),
    .ss_in_n  (ss_in_n),
    .cs_n     (cs_n)
);

// File: tb/tb_spi_psel_master.sv
`timescale 1ns/1ps
module tb_spi_psel_master;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso = 1'b0;
    logic [3:0]  cs_n;
    logic        ss_in_n = 1'b1;

    int n_tests = 0, n_fail = 0;

    spi_psel_master dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .ss_in_n(ss_in_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // configuration model
    int c_div[4], c_setup[4], c_gap[4], c_len[4], c_cpol[4], c_cpha[4];

    // slave model state
    int          cur_cpol = 0, cur_cpha = 0, cur_n = 8;
    logic [15:0] slv_word = '0, slv_rx = '0;
    logic [3:0]  seen_cs = 4'hF;
    int          cyc = 0, t_fall = 0, t_rise = 0, first_dly = 0, gap_meas = 0;
    int          edges = 0, idx = 0, started = 0, done_cnt = 0;
    logic        idle_lvl = 1'b0, p_sel = 1'b0, p_sclk = 1'b0;

    always @(negedge clk) begin
        logic sel, lead;
        cyc++;
        sel = ~&cs_n;
        if (sel && !p_sel) begin
            t_fall   = cyc;
            gap_meas = cyc - t_rise;
            edges    = 0;
            slv_rx   = '0;
            seen_cs  = cs_n;
            idle_lvl = sclk;
            idx      = cur_cpha ? cur_n : cur_n - 1;
            miso     = slv_word[cur_n-1];
            started++;
        end else if (p_sel && sclk != p_sclk) begin
            if (edges == 0) first_dly = cyc - t_fall;
            lead = (sclk != cur_cpol[0]);
            if (lead ^ cur_cpha[0]) begin
                slv_rx = {slv_rx[14:0], mosi};
            end else begin
                idx--;
                if (idx >= 0) miso = slv_word[idx];
            end
            edges++;
        end
        if (!sel && p_sel) begin
            t_rise = cyc;
            done_cnt++;
        end
        p_sel  = sel;
        p_sclk = sclk;
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic int maxi(input int a, input int b);
        return (a < b) ? b : a;
    endfunction

    function automatic int exp_idx(input logic [3:0] code, input bit dec);
        if (dec) return int'(code[3:2]);
        for (int i = 0; i < 4; i++) if (!code[i]) return i;
        return 3;
    endfunction

    function automatic logic [3:0] exp_lines(input logic [3:0] code, input bit dec);
        if (dec || code == 4'hF) return code;
        return ~(4'b0001 << exp_idx(code, 1'b0));
    endfunction

    function automatic int exp_bits(input int len);
        return (len > 8) ? 16 : 8 + len;
    endfunction

    task automatic set_cfg(input int i, input int dv, input int su, input int gp,
                           input int ln, input int po, input int ph);
        c_div[i] = dv; c_setup[i] = su; c_gap[i] = gp; c_len[i] = ln; c_cpol[i] = po; c_cpha[i] = ph;
        bus_write(4'(8 + i), {6'(gp), 8'(su), 10'(dv), 2'b00, 1'(ph), 1'(po), 4'(ln)});
    endtask

    task automatic prep_slave(input int ci);
        cur_cpol = c_cpol[ci];
        cur_cpha = c_cpha[ci];
        cur_n    = exp_bits(c_len[ci]);
        slv_word = 16'($urandom);
    endtask

    // checks of one finished word against the models
    task automatic check_word(input logic [3:0] code, input bit dec, input logic [15:0] data);
        logic [31:0] rd;
        int ci, n, h;
        logic [15:0] m;
        ci = exp_idx(code, dec);
        n  = exp_bits(c_len[ci]);
        h  = maxi(c_div[ci], 1);
        m  = 16'hFFFF >> (16 - n);
        chk(dec ? "R10" : "R9", "select pattern", seen_cs, exp_lines(code, dec));
        chk("R3", "edge count", edges, 2 * n);
        chk("R3", "clock idle level", idle_lvl, c_cpol[ci]);
        chk("R3", "bits seen on mosi", slv_rx & m, data & m);
        chk("R4", "setup delay", first_dly, maxi(c_setup[ci], h));
        chk("R11", "lines released", cs_n, 4'hF);
        bus_read(4'd3, rd);
        chk("R3", "received data", rd[15:0], slv_word & m);
        chk("R11", "received code", rd[19:16], code);
    endtask

    task automatic wait_done(input int d0);
        while (done_cnt == d0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic one_word(input bit vsel, input bit dec, input logic [3:0] mcode,
                            input logic [3:0] tcode, input logic [15:0] data);
        logic [3:0] code;
        int d0;
        code = vsel ? tcode : mcode;
        bus_write(4'd1, {24'b0, mcode, 2'b00, dec, vsel});
        prep_slave(exp_idx(code, dec));
        d0 = done_cnt;
        bus_write(4'd2, {12'b0, tcode, data});
        wait_done(d0);
        check_word(code, dec, data);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R2 watchdog expired: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int d0, s0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin
            c_div[i] = 0; c_setup[i] = 0; c_gap[i] = 0; c_len[i] = 0; c_cpol[i] = 0; c_cpha[i] = 0;
        end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1", "cs_n after reset", cs_n, 4'hF);
        chk("R1", "sclk after reset", sclk, 1'b0);
        bus_read(4'd4, rd);
        chk("R1", "status after reset", rd[3:0], 4'h1);

        // R1: disabled master holds a written word
        prep_slave(0);
        bus_write(4'd2, 32'h0000_00A5);
        repeat (20) @(negedge clk);
        chk("R1", "no start while disabled", started, 0);
        bus_read(4'd4, rd);
        chk("R1", "word waits while disabled", rd[0], 1'b0);
        d0 = done_cnt;
        bus_write(4'd0, 32'h1);
        wait_done(d0);
        bus_read(4'd4, rd);
        chk("R2", "transmit empty after start", rd[0], 1'b1);
        check_word(4'h0, 1'b0, 16'h00A5);

        // random words across modes and configurations
        for (int k = 0; k < 40; k++) begin
            if (k % 4 == 0)
                for (int i = 0; i < 4; i++)
                    set_cfg(i, int'($urandom_range(0, 3)), int'($urandom_range(0, 6)),
                            int'($urandom_range(0, 5)), int'($urandom_range(0, 9)),
                            int'($urandom_range(0, 1)), int'($urandom_range(0, 1)));
            begin
                bit vsel, dec;
                logic [3:0] mc, tc;
                vsel = 1'($urandom);
                dec  = 1'($urandom);
                mc   = 4'($urandom_range(0, 14));
                tc   = 4'($urandom_range(0, 14));
                if (!vsel) tc = 4'($urandom);
                one_word(vsel, dec, mc, tc, 16'($urandom)); // R7 R8 R9 R10
            end
        end

        // R2 R5 R6: queued word, gap length, overrun
        set_cfg(0, 2, 3, 4, 0, 0, 0);
        bus_write(4'd1, 32'h0000_0000);
        prep_slave(0);
        d0 = done_cnt;
        bus_write(4'd2, 32'h0000_003C);
        rd = '0;
        while (!rd[0]) bus_read(4'd4, rd);
        bus_write(4'd2, 32'h0000_00C3);
        while (done_cnt < d0 + 2) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R5", "gap between queued words", gap_meas, 5);
        chk("R2", "queued word shifted", slv_rx[7:0], 8'hC3);
        bus_read(4'd4, rd);
        chk("R6", "overrun set", rd[3:0], 4'h7);
        bus_read(4'd4, rd);
        chk("R6", "overrun cleared by status read", rd[3:0], 4'h3);
        bus_read(4'd3, rd);
        chk("R6", "newest word kept", rd[7:0], slv_word[7:0]);
        bus_read(4'd4, rd);
        chk("R6", "receive full cleared by read", rd[3:0], 4'h1);

        // R9: code 1111 in direct mode selects nothing
        bus_write(4'd1, 32'h0000_00F0);
        s0 = started;
        bus_write(4'd2, 32'h0000_0011);
        repeat (80) @(negedge clk);
        chk("R9", "no line for code 1111", started, s0);
        bus_read(4'd4, rd);
        chk("R9", "word still completes", rd[3:0], 4'h3);
        bus_read(4'd3, rd);
        chk("R11", "code 1111 stored", rd[19:16], 4'hF);

        // R12: mode fault
        bus_write(4'd1, 32'h0000_0000);
        @(negedge clk) ss_in_n = 1'b0;
        @(negedge clk) ss_in_n = 1'b1;
        bus_read(4'd0, rd);
        chk("R12", "master disabled by fault", rd[0], 1'b0);
        bus_read(4'd4, rd);
        chk("R12", "fault flag set", rd[3], 1'b1);
        bus_read(4'd4, rd);
        chk("R12", "fault flag cleared by read", rd[3], 1'b0);
        s0 = started;
        prep_slave(0);
        bus_write(4'd2, 32'h0000_0055);
        repeat (40) @(negedge clk);
        chk("R12", "no start after fault", started, s0);
        d0 = done_cnt;
        bus_write(4'd0, 32'h1);
        wait_done(d0);
        check_word(4'h0, 1'b0, 16'h0055);

        // R13: disable via control bit1
        bus_write(4'd0, 32'h2);
        s0 = started;
        bus_write(4'd2, 32'h0000_0077);
        repeat (40) @(negedge clk);
        chk("R13", "no start after disable", started, s0);
        chk("R13", "lines high while disabled", cs_n, 4'hF);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule